// File: doc/BRIEF.md
# MSK Byte Transmitter with Checksum Insertion

This block turns bytes written by a host into a continuous-phase MSK sample stream at one of two baud rates. The host places one byte at a time into a single holding buffer and watches a buffer-empty flag to know when the next byte may be written. Preambles and frame sync words carry no special handling; the host writes them like any other data. The stream is produced by a phase accumulator. On every sample tick it advances by a mark or a space increment, so the waveform has no phase step at any bit edge.

A checksum-enable level marks a span of bytes. Bytes moved into the shifter while the level is high are folded into a CRC-16, which uses polynomial 0x1021 and starts from all ones. When the level falls, the byte in flight finishes and the two CRC bytes go out next, high byte first. When nothing is left to send at a byte boundary, one trailing hang bit is sent and the transmitter goes idle. Analogue filtering and output level control lie outside this block.

Top module: `msk_byte_tx`

## Requirements
- R1: After reset, bufEmpty is 1, busy is 0 and sample is 0.
- R2: Each byte is sent most significant bit first. Bytes that are ready at a boundary follow one another with no gap and no extra bits.
- R3: A sample tick occurs every CLK_DIV clocks while enabled, and the phase advances once per tick. With rateFast=0 (1200 baud) a bit lasts SPB ticks, a 1 adds 2^PHASE_W/SPB and a 0 adds 1.5 times that. With rateFast=1 (2400 baud) a bit lasts SPB/2 ticks, a 1 adds 2^PHASE_W/SPB and a 0 adds twice that.
- R4: While busy, every change of sample is exactly one mark or one space increment. While idle, sample holds its value.
- R5: A write while bufEmpty=1 is accepted, and bufEmpty reads 0 one clock later. bufEmpty returns to 1 when the byte moves into the shifter. A write while bufEmpty=0 is ignored.
- R6: The CRC is preset to 0xFFFF when chkEn rises. It covers every byte taken from the buffer while chkEn=1, processed MSB first with polynomial 0x1021 and no final inversion.
- R7: When chkEn falls, the byte in flight completes, then CRC bits 15..8 and then bits 7..0 are sent, ahead of any buffered byte.
- R8: When no CRC byte is pending and the buffer is empty at the end of a byte, a single 1 bit (the hang bit) is sent, after which busy falls to 0.
- R9: While enable=0 the transmission stops at once, busy reads 0, the buffer is emptied, pending CRC bytes are dropped, writes are ignored and sample holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| enable | input | 1 | Transmitter enable; low aborts and clears |
| rateFast | input | 1 | 0 = 1200 baud, 1 = 2400 baud |
| chkEn | input | 1 | Checksum span marker |
| wrStb | input | 1 | Write strobe for the holding buffer |
| wrData | input | 8 | Byte to transmit |
| sample | output | PHASE_W | Accumulated phase (modulation sample) |
| bufEmpty | output | 1 | Holding buffer can take a byte |
| busy | output | 1 | A symbol (data, CRC or hang bit) is being sent |

## Verification
The bench decodes the sample stream back into bits by looking at phase deltas and counting ticks per bit. It compares the result with a bit list built from the requirements. The byte patterns include alternating, all-ones, all-zeros and single-bit values at both rates. These show whether bit order is reversed and whether the two space increments or the bit lengths have been swapped. The checksum runs either start at the first byte or skip a leading byte, which separates a CRC that covers the wrong span or has the wrong preset from a correct one. Further directed runs cover a write into a full buffer, an abort in mid-byte with writes while disabled, and an idle stretch.

// File: rtl/msk_tx_pkg.sv
package msk_tx_pkg;

  typedef struct packed {
    logic       tick;
    logic       clear;
    logic       load;
    logic       loadHang;
    logic [7:0] loadData;
  } txStrobes_t;

  localparam logic HANG_VALUE = 1'b1;
  localparam logic [15:0] CRC_POLY = 16'h1021;
  localparam logic [15:0] CRC_PRESET = 16'hFFFF;

  function automatic logic [15:0] crcAddByte(input logic [15:0] crcIn, input logic [7:0] dataIn);
    logic [15:0] acc;
    acc = crcIn;
    for (int i = 7; i >= 0; i--) begin
      if (acc[15] ^ dataIn[i]) acc = {acc[14:0], 1'b0} ^ CRC_POLY;
      else                     acc = {acc[14:0], 1'b0};
    end
    return acc;
  endfunction

endpackage

// File: rtl/msk_tx_datapath.sv
module msk_tx_datapath
  import msk_tx_pkg::*;
#(
  parameter int PHASE_W = 8,
  parameter int SPB     = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               rateFast,
  input  txStrobes_t         st,
  output logic               running,
  output logic               symDone,
  output logic [PHASE_W-1:0] phase
);
  localparam int CNT_W = $clog2(SPB);
  localparam logic [PHASE_W-1:0] MARK_INC   = PHASE_W'((1 << PHASE_W) / SPB);
  localparam logic [PHASE_W-1:0] SLOW_SPACE = PHASE_W'(((1 << PHASE_W) / SPB) * 3 / 2);
  localparam logic [PHASE_W-1:0] FAST_SPACE = PHASE_W'(((1 << PHASE_W) / SPB) * 2);
  localparam logic [CNT_W-1:0]   LAST_SLOW  = CNT_W'(SPB - 1);
  localparam logic [CNT_W-1:0]   LAST_FAST  = CNT_W'(SPB / 2 - 1);

  logic [7:0]         shiftReg;
  logic [3:0]         bitsLeft;
  logic [CNT_W-1:0]   sampleCnt;
  logic [CNT_W-1:0]   lastSample;
  logic               atBitEnd;
  logic [PHASE_W-1:0] phaseInc;
  logic [7:0]         loadValue;
  logic [3:0]         loadLen;

  assign lastSample = rateFast ? LAST_FAST : LAST_SLOW;
  assign atBitEnd   = (sampleCnt == lastSample);
  assign phaseInc   = shiftReg[7] ? MARK_INC : (rateFast ? FAST_SPACE : SLOW_SPACE);
  assign symDone    = st.tick && running && atBitEnd && (bitsLeft == 4'd1);
  assign loadValue  = st.loadHang ? {HANG_VALUE, 7'b0} : st.loadData;
  assign loadLen    = st.loadHang ? 4'd1 : 4'd8;

  always_ff @(posedge clk) begin
    if (rst) begin
      running   <= 1'b0;
      shiftReg  <= '0;
      bitsLeft  <= '0;
      sampleCnt <= '0;
      phase     <= '0;
    end else if (st.clear) begin
      running   <= 1'b0;
      sampleCnt <= '0;
    end else if (st.tick) begin
      if (running) begin
        phase <= phase + phaseInc;
        if (atBitEnd) begin
          sampleCnt <= '0;
          if (bitsLeft == 4'd1) begin
            if (st.load) begin
              shiftReg <= loadValue;
              bitsLeft <= loadLen;
            end else begin
              running <= 1'b0;
            end
          end else begin
            shiftReg <= {shiftReg[6:0], 1'b0};
            bitsLeft <= bitsLeft - 4'd1;
          end
        end else begin
          sampleCnt <= sampleCnt + 1'b1;
        end
      end else if (st.load) begin
        shiftReg  <= loadValue;
        bitsLeft  <= loadLen;
        sampleCnt <= '0;
        running   <= 1'b1;
      end
    end
  end

  // R4: phase moves by exactly one legal increment per active tick
  a_r4_phase_step: assert property (@(posedge clk) disable iff (rst)
    (st.tick && running && !st.clear) |=>
      (((phase - $past(phase)) == MARK_INC) || ((phase - $past(phase)) == SLOW_SPACE) ||
       ((phase - $past(phase)) == FAST_SPACE)));

  // R4: phase frozen while no symbol is in flight
  a_r4_idle_hold: assert property (@(posedge clk) disable iff (rst)
    !running |=> $stable(phase));

  // R2: symbol length register stays within one byte
  a_r2_bits_range: assert property (@(posedge clk) disable iff (rst)
    running |-> (bitsLeft >= 4'd1 && bitsLeft <= 4'd8));

  // R9: clear stops the symbol engine
  a_r9_clear_stops: assert property (@(posedge clk) disable iff (rst)
    st.clear |=> !running);

endmodule

// File: rtl/msk_tx_ctrl.sv
module msk_tx_ctrl
  import msk_tx_pkg::*;
#(
  parameter int CLK_DIV = 4
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       enable,
  input  logic       chkEn,
  input  logic       wrStb,
  input  logic [7:0] wrData,
  input  logic       running,
  input  logic       symDone,
  output txStrobes_t st,
  output logic       bufEmpty
);
  localparam int DIV_W = (CLK_DIV > 1) ? $clog2(CLK_DIV) : 1;
  localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(CLK_DIV - 1);

  logic [DIV_W-1:0] divCnt;
  logic             tick;
  logic [7:0]       bufData;
  logic             bufFull;
  logic [15:0]      crcReg;
  logic [1:0]       crcLeft;
  logic             chkPrev;
  logic             inHang;
  logic             decide;
  logic             takeBuf;
  logic             takeCrc;
  logic             chkRise;
  logic             chkFall;
  logic [15:0]      crcBase;

  assign tick     = enable && (divCnt == DIV_LAST);
  assign decide   = symDone || (tick && !running);
  assign chkRise  = chkEn && !chkPrev;
  assign chkFall  = !chkEn && chkPrev;
  assign crcBase  = chkRise ? CRC_PRESET : crcReg;
  assign bufEmpty = !bufFull;

  always_comb begin
    st          = '0;
    st.tick     = tick;
    st.clear    = !enable;
    takeBuf     = 1'b0;
    takeCrc     = 1'b0;
    if (decide) begin
      if (crcLeft == 2'd2) begin
        st.load = 1'b1; st.loadData = crcReg[15:8]; takeCrc = 1'b1;
      end else if (crcLeft == 2'd1) begin
        st.load = 1'b1; st.loadData = crcReg[7:0]; takeCrc = 1'b1;
      end else if (bufFull) begin
        st.load = 1'b1; st.loadData = bufData; takeBuf = 1'b1;
      end else if (running && !inHang) begin
        st.load = 1'b1; st.loadHang = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      divCnt  <= '0;
      bufData <= '0;
      bufFull <= 1'b0;
      crcReg  <= CRC_PRESET;
      crcLeft <= '0;
      chkPrev <= 1'b0;
      inHang  <= 1'b0;
    end else begin
      chkPrev <= chkEn;
      if (!enable) begin
        divCnt  <= '0;
        bufFull <= 1'b0;
        crcLeft <= '0;
        inHang  <= 1'b0;
      end else begin
        divCnt <= tick ? '0 : divCnt + 1'b1;
        if (takeBuf) bufFull <= 1'b0;
        else if (wrStb && !bufFull) begin
          bufFull <= 1'b1;
          bufData <= wrData;
        end
        if (chkFall) crcLeft <= 2'd2;
        else if (takeCrc) crcLeft <= crcLeft - 2'd1;
        if (st.load) inHang <= st.loadHang;
      end
      if (takeBuf && chkEn) crcReg <= crcAddByte(crcBase, bufData);
      else if (chkRise)     crcReg <= CRC_PRESET;
    end
  end

  // R5: a byte moved to the shifter frees the buffer
  a_r5_take_frees: assert property (@(posedge clk) disable iff (rst)
    (takeBuf && enable) |=> bufEmpty);

  // R5: a write into a full buffer does not disturb its byte
  a_r5_full_ignored: assert property (@(posedge clk) disable iff (rst)
    (bufFull && wrStb && !takeBuf && enable) |=> (bufFull && $stable(bufData)));

  // R7: at most two checksum bytes pending
  a_r7_crc_count: assert property (@(posedge clk) disable iff (rst)
    crcLeft != 2'd3);

  // R8: after the hang bit with nothing queued the engine stops
  a_r8_hang_ends: assert property (@(posedge clk) disable iff (rst)
    (symDone && inHang && !bufFull && crcLeft == 2'd0 && !chkFall && enable) |=> !running);

  // R9: disable empties the buffer
  a_r9_disable_empties: assert property (@(posedge clk) disable iff (rst)
    !enable |=> bufEmpty);

endmodule

// File: rtl/msk_byte_tx.sv
module msk_byte_tx
  import msk_tx_pkg::*;
#(
  parameter int PHASE_W = 8,
  parameter int SPB     = 8,
  parameter int CLK_DIV = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               enable,
  input  logic               rateFast,
  input  logic               chkEn,
  input  logic               wrStb,
  input  logic [7:0]         wrData,
  output logic [PHASE_W-1:0] sample,
  output logic               bufEmpty,
  output logic               busy
);
  txStrobes_t strobes;
  logic       running;
  logic       symDone;

  msk_tx_ctrl #(.CLK_DIV(CLK_DIV)) u_ctrl (
    .clk(clk), .rst(rst), .enable(enable), .chkEn(chkEn), .wrStb(wrStb),
    .wrData(wrData), .running(running), .symDone(symDone), .st(strobes),
    .bufEmpty(bufEmpty)
  );

  msk_tx_datapath #(.PHASE_W(PHASE_W), .SPB(SPB)) u_dp (
    .clk(clk), .rst(rst), .rateFast(rateFast), .st(strobes),
    .running(running), .symDone(symDone), .phase(sample)
  );

  assign busy = running;

endmodule

// File: tb/sim_msk_byte_tx.sv
module sim_msk_byte_tx;
  localparam int PHASE_W = 8;
  localparam int SPB     = 8;
  localparam int CLK_DIV = 4;
  localparam int MARK    = 32;
  localparam int SPACE_S = 48;
  localparam int SPACE_F = 64;
  localparam int NOCHK   = 3;

  typedef struct packed {
    logic       rate;
    logic [1:0] nBytes;
    logic [1:0] chkFirst;
    logic [7:0] b0;
    logic [7:0] b1;
    logic [7:0] b2;
  } vec_t;

  localparam vec_t VECS [5] = '{
    '{1'b0, 2'd3, 2'd3, 8'hA5, 8'h3C, 8'h01},
    '{1'b1, 2'd3, 2'd3, 8'hC3, 8'h7E, 8'h80},
    '{1'b0, 2'd3, 2'd0, 8'h31, 8'h32, 8'h33},
    '{1'b1, 2'd3, 2'd1, 8'hFF, 8'h00, 8'h5A},
    '{1'b1, 2'd2, 2'd0, 8'h12, 8'h34, 8'h00}
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic enable = 1'b0;
  logic rateFast = 1'b0;
  logic chkEn = 1'b0;
  logic wrStb = 1'b0;
  logic [7:0] wrData = 8'h00;
  logic [PHASE_W-1:0] sample;
  logic bufEmpty;
  logic busy;

  int checks = 0;
  int fails = 0;
  logic gotBits [0:511];
  int gotN = 0;
  int tickInBit = 0;
  int badDelta = 0;
  logic [PHASE_W-1:0] prevSample = '0;
  logic [PHASE_W-1:0] delta;
  logic expBits [0:127];
  int expN;

  always #2 clk = ~clk;

  msk_byte_tx #(.PHASE_W(PHASE_W), .SPB(SPB), .CLK_DIV(CLK_DIV)) u0 (
    .clk(clk), .rst(rst), .enable(enable), .rateFast(rateFast), .chkEn(chkEn),
    .wrStb(wrStb), .wrData(wrData), .sample(sample), .bufEmpty(bufEmpty), .busy(busy)
  );

  // stream decoder: phase deltas to bits
  always @(negedge clk) begin
    delta = sample - prevSample;
    prevSample = sample;
    if (!rst && delta != '0) begin
      if (int'(delta) == MARK) begin
        if (tickInBit == (rateFast ? SPB/2 : SPB) - 1) begin
          if (gotN < 512) gotBits[gotN] = 1'b1;
          gotN++;
          tickInBit = 0;
        end else tickInBit++;
      end else if (int'(delta) == (rateFast ? SPACE_F : SPACE_S)) begin
        if (tickInBit == (rateFast ? SPB/2 : SPB) - 1) begin
          if (gotN < 512) gotBits[gotN] = 1'b0;
          gotN++;
          tickInBit = 0;
        end else tickInBit++;
      end else badDelta++;
    end else if (!busy) tickInBit = 0;
  end

  function automatic logic [15:0] refCrc(input logic [15:0] c, input logic [7:0] d);
    logic [15:0] r = c ^ {d, 8'h00};
    for (int k = 0; k < 8; k++) r = r[15] ? ((r << 1) ^ 16'h1021) : (r << 1);
    return r;
  endfunction

  task automatic check(input logic ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic addByte(input logic [7:0] b);
    for (int k = 7; k >= 0; k--) begin
      expBits[expN] = b[k];
      expN++;
    end
  endtask

  task automatic writeByte(input logic [7:0] b);
    @(negedge clk);
    wrStb = 1'b1; wrData = b;
    @(negedge clk);
    wrStb = 1'b0;
  endtask

  task automatic waitEmpty();
    while (!bufEmpty) @(negedge clk);
  endtask

  task automatic waitIdle();
    repeat (3 * CLK_DIV) @(negedge clk);
    while (busy) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic compareStream(input int base, input string tag);
    int mism = 0;
    int firstBad = -1;
    check(gotN - base == expN, {tag, " bit count"}, gotN - base, expN);
    for (int k = 0; k < expN && base + k < 512; k++) begin
      if (gotBits[base + k] !== expBits[k]) begin
        mism++;
        if (firstBad < 0) firstBad = k;
      end
    end
    check(mism == 0, {tag, " bit mismatches (first index reported as actual)"}, firstBad, -1);
  endtask

  initial begin
    int base;
    logic [PHASE_W-1:0] held;
    logic [15:0] crc;
    logic [7:0] bytes [3];

    repeat (3) @(negedge clk);
    // R1 reset state
    check(bufEmpty === 1'b1, "R1 bufEmpty after reset", int'(bufEmpty), 1);
    check(busy === 1'b0, "R1 busy after reset", int'(busy), 0);
    check(sample === '0, "R1 sample after reset", int'(sample), 0);
    rst = 1'b0;
    enable = 1'b1;
    @(negedge clk);

    // table: R2 R3 R6 R7 R8
    for (int v = 0; v < 5; v++) begin
      rateFast = VECS[v].rate;
      base = gotN;
      bytes[0] = VECS[v].b0; bytes[1] = VECS[v].b1; bytes[2] = VECS[v].b2;
      expN = 0;
      crc = 16'hFFFF;
      for (int i = 0; i < int'(VECS[v].nBytes); i++) begin
        addByte(bytes[i]);
        if (int'(VECS[v].chkFirst) != NOCHK && i >= int'(VECS[v].chkFirst)) crc = refCrc(crc, bytes[i]);
      end
      if (int'(VECS[v].chkFirst) != NOCHK) begin
        addByte(crc[15:8]);
        addByte(crc[7:0]);
      end
      expBits[expN] = 1'b1;
      expN++;
      for (int i = 0; i < int'(VECS[v].nBytes); i++) begin
        waitEmpty();
        if (i == int'(VECS[v].chkFirst)) chkEn = 1'b1;
        writeByte(bytes[i]);
        if (i == 0) check(bufEmpty === 1'b0, "R5 buffer full after write", int'(bufEmpty), 0);
      end
      if (int'(VECS[v].chkFirst) != NOCHK) begin
        waitEmpty();
        chkEn = 1'b0;
      end
      waitIdle();
      compareStream(base, $sformatf("R2/R6/R7/R8 vector %0d", v));
    end
    check(badDelta == 0, "R3/R4 illegal phase steps", badDelta, 0);

    // R5 write into full buffer is ignored
    rateFast = 1'b0;
    base = gotN;
    expN = 0;
    addByte(8'h96);
    expBits[expN] = 1'b1;
    expN++;
    @(negedge clk);
    wrStb = 1'b1; wrData = 8'h96;
    @(negedge clk);
    wrData = 8'h0F;
    @(negedge clk);
    wrStb = 1'b0;
    waitIdle();
    compareStream(base, "R5 second write ignored");

    // R4 idle hold
    held = sample;
    repeat (40) @(negedge clk);
    check(sample === held, "R4 sample holds while idle", int'(sample), int'(held));
    check(busy === 1'b0, "R8 idle after hang bit", int'(busy), 0);

    // R9 abort while sending with a byte buffered and checksum pending
    chkEn = 1'b1;
    writeByte(8'hE7);
    waitEmpty();
    writeByte(8'h18);
    chkEn = 1'b0;
    repeat (60) @(negedge clk);
    enable = 1'b0;
    repeat (2) @(negedge clk);
    check(busy === 1'b0, "R9 busy after disable", int'(busy), 0);
    check(bufEmpty === 1'b1, "R9 buffer cleared by disable", int'(bufEmpty), 1);
    writeByte(8'h55);
    check(bufEmpty === 1'b1, "R9 write ignored while disabled", int'(bufEmpty), 1);
    held = sample;
    repeat (30) @(negedge clk);
    check(sample === held, "R9 sample holds while disabled", int'(sample), int'(held));
    enable = 1'b1;
    base = gotN;
    repeat (200) @(negedge clk);
    check(busy === 1'b0, "R9 nothing resumes after re-enable", int'(busy), 0);
    check(gotN == base, "R9 no bits after re-enable", gotN - base, 0);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule